// File: doc/BRIEF.md
# Bridge Control Register Bank

This block holds the configuration state of a system bridge as a bank of 28 words of 32 bits each. A CPU reaches it through a simple memory-mapped port with one request per cycle. The register index is the byte offset shifted right by two. The bank covers general configuration, GPIO data and enables, interrupt-controller setup, four mailboxes, cache control, and timing and memory-size words. The logic that acts on these settings lives elsewhere. It reads the words it needs, and the interrupt enable mask is brought out on its own port.

Three words have side effects. The interrupt enable mask cannot be written directly. One alias word sets bits in it and another alias word clears bits in it. The mask itself and the interrupt status word ignore writes. When a write turns one bit of the general configuration word from 0 to 1, the block raises a one-cycle request for a system reset.

Read data is registered, so it appears one cycle after the request. Offsets that hold no register read as zero and ignore writes. A hardware reset loads the fixed power-on values.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After hardware reset, reads return these values and every other defined word reads zero:
  - 0x00 = 0x00000C40
  - 0x04 = 0x00001384 (bits 2, 7, 8, 9, 12)
  - 0x08 = 0x2BFF8010
  - 0x0C = 0x255E0091
  - 0x10 = 0x00006140
  - 0x1C = 0x000001FF
  - 0x20 = 0x000001FF
  - 0x68 = 0x00000008
  - 0x6C = 0x10000000
- R2: An access counts only when `req_size` is 2'b10, meaning 32 bits. For any other size, a write changes nothing and a read returns zero.
- R3: The register index is `req_addr >> 2`. A 32-bit access with `req_addr[1:0]` not zero is treated like a sub-word access: a write is ignored and a read returns zero.
- R4: A write to offset 0x30 stores the value in that word and ORs it into the interrupt enable mask.
- R5: A write to offset 0x34 stores the value in that word and clears the matching bits of the enable mask.
- R6: The enable mask word (0x38) and the interrupt status word (0x3C) keep their contents when written.
- R7: When a write to offset 0x04 changes bit 2 from 0 to 1, the new value is stored and `reset_req` is high for exactly the one cycle after the write edge. A write that leaves bit 2 at 1, or clears it, gives no pulse.
- R8: Offsets 0x70 and above hold no register. Writes to them change nothing, and reads of them return zero.
- R9: Every read request gives `rd_valid` high with its data one clock edge later. `rd_valid` is low in every other cycle.
- R10: Every other defined word stores all 32 bits that are written to it.
- R11: `int_enable` always equals the contents of the enable mask word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 treated as not a word |
| req_addr | input | ADDR_W (8) | Byte offset into the bank |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read request |
| rd_data | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |
| int_enable | output | 32 | Current interrupt enable mask |

## Verification
The bench first reads every word after reset, which tells a wrong power-on constant apart from a decode fault. Directed writes then separate the cases that share the write path:
- plain words;
- the set and clear aliases, using overlapping masks so that an OR cannot be confused with a store;
- the read-only words;
- misaligned, sub-word and out-of-range offsets.

The configuration reset bit is driven through 1→1, 1→0 and 0→1, so that a level detector can be told apart from an edge detector. A long pseudo-random stream of mixed reads and writes is compared cycle by cycle against a behavioural model. This catches ordering slips between a read and the write before it.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    parameter int DATA_W   = 32;
    parameter int NUM_REGS = 28;
    localparam int SEL_W   = $clog2(NUM_REGS);

    // Word indices whose behaviour differs from plain storage
    localparam int IDX_GEN    = 1;
    localparam int IDX_ENSET  = 12;
    localparam int IDX_ENCLR  = 13;
    localparam int IDX_INTEN  = 14;
    localparam int IDX_ISTAT  = 15;
    localparam int RST_BIT    = 2;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    typedef enum logic [2:0] {
        K_PLAIN,
        K_GEN,
        K_SET,
        K_CLR,
        K_RO
    } wkind_e;

    function automatic wkind_e kind_of(input logic [SEL_W-1:0] sel);
        case (int'(sel))
            IDX_GEN:              kind_of = K_GEN;
            IDX_ENSET:            kind_of = K_SET;
            IDX_ENCLR:            kind_of = K_CLR;
            IDX_INTEN, IDX_ISTAT: kind_of = K_RO;
            default:              kind_of = K_PLAIN;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] power_on_value(input int idx);
        case (idx)
            0:       power_on_value = 32'h0000_0C40;
            1:       power_on_value = 32'h0000_1384;
            2:       power_on_value = 32'h2BFF_8010;
            3:       power_on_value = 32'h255E_0091;
            4:       power_on_value = 32'h0000_6140;
            7, 8:    power_on_value = 32'h0000_01FF;
            26:      power_on_value = 32'h0000_0008;
            27:      power_on_value = 32'h1000_0000;
            default: power_on_value = '0;
        endcase
    endfunction

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              wr_en,
    output logic              rd_en,
    output logic              rd_hit,
    output logic [SEL_W-1:0]  sel
);

    logic [IDX_W-1:0] idx;
    logic             word_ok;
    logic             defined;

    always_comb begin
        idx     = req_addr[ADDR_W-1:2];
        word_ok = (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00);
        defined = int'(idx) < NUM_REGS;
        sel     = defined ? idx[SEL_W-1:0] : '0;
        wr_en   = req_valid && req_write && word_ok && defined;
        rd_en   = req_valid && !req_write;
        rd_hit  = rd_en && word_ok && defined;
    end

endmodule

// File: rtl/bcr_store.sv
module bcr_store
    import bcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] words [NUM_REGS],
    output logic              reset_req,
    output logic [DATA_W-1:0] int_enable
);

    typedef struct {
        logic [DATA_W-1:0] word [NUM_REGS];
        logic              rst_req;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (wr_en) begin
            case (kind_of(sel))
                K_PLAIN: st_d.word[sel] = wdata;
                K_GEN: begin
                    st_d.word[sel] = wdata;
                    st_d.rst_req   = !st_q.word[IDX_GEN][RST_BIT] && wdata[RST_BIT];
                end
                K_SET: begin
                    st_d.word[sel]       = wdata;
                    st_d.word[IDX_INTEN] = st_q.word[IDX_INTEN] | wdata;
                end
                K_CLR: begin
                    st_d.word[sel]       = wdata;
                    st_d.word[IDX_INTEN] = st_q.word[IDX_INTEN] & ~wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                st_q.word[i] <= power_on_value(i);
            end
            st_q.rst_req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign words[g] = st_q.word[g];
    end
    assign reset_req  = st_q.rst_req;
    assign int_enable = st_q.word[IDX_INTEN];

    p_set_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && int'(sel) == IDX_ENSET |=> ((int_enable & $past(wdata)) == $past(wdata)));

    p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && int'(sel) == IDX_ENCLR |=> ((int_enable & $past(wdata)) == '0));

    p_en_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && int'(sel) == IDX_INTEN |=> $stable(int_enable));

    p_stat_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && int'(sel) == IDX_ISTAT |=> $stable(st_q.word[IDX_ISTAT]));

    p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(wr_en) && int'($past(sel)) == IDX_GEN);

endmodule

// File: rtl/bcr_rdport.sv
module bcr_rdport
    import bcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_hit,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] words [NUM_REGS],
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.valid = rd_en;
        rd_d.data  = rd_hit ? words[sel] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_hit |=> rd_data == '0);

endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              reset_req,
    output logic [31:0]       int_enable
);

    logic             wr_en;
    logic             rd_en;
    logic             rd_hit;
    logic [SEL_W-1:0] sel;
    logic [DATA_W-1:0] words [NUM_REGS];

    bcr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rd_hit    (rd_hit),
        .sel       (sel)
    );

    bcr_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .sel        (sel),
        .wdata      (req_wdata),
        .words      (words),
        .reset_req  (reset_req),
        .int_enable (int_enable)
    );

    bcr_rdport u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_hit   (rd_hit),
        .sel      (sel),
        .words    (words),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    p_wr_defined_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(req_addr >> 2) < NUM_REGS);

endmodule

// File: tb/bridge_ctrl_regs_bench.sv
module bridge_ctrl_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        reset_req;
    logic [31:0] int_enable;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m [NREG];
    logic        exp_rv;
    logic [31:0] exp_rd;
    logic        exp_rr;

    bridge_ctrl_regs u_bridge_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .reset_req(reset_req),
        .int_enable(int_enable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] por(input int i);
        case (i)
            0: return 32'h0000_0C40;
            1: return 32'h0000_1384;
            2: return 32'h2BFF_8010;
            3: return 32'h255E_0091;
            4: return 32'h0000_6140;
            7: return 32'h0000_01FF;
            8: return 32'h0000_01FF;
            26: return 32'h0000_0008;
            27: return 32'h1000_0000;
            default: return 32'h0;
        endcase
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) m[i] = por(i);
            exp_rv = 1'b0; exp_rd = '0; exp_rr = 1'b0;
        end else begin
            int  idx;
            bit  ok;
            exp_rv = 1'b0; exp_rr = 1'b0; exp_rd = '0;
            if (req_valid) begin
                idx = int'(req_addr) / 4;
                ok  = (req_size == 2'b10) && (req_addr % 4 == 0) && (idx < NREG);
                if (!req_write) begin
                    exp_rv = 1'b1;
                    exp_rd = ok ? m[idx] : 32'h0;
                end else if (ok) begin
                    if (idx == 14 || idx == 15) begin
                    end else if (idx == 12) begin
                        m[12] = req_wdata; m[14] = m[14] | req_wdata;
                    end else if (idx == 13) begin
                        m[13] = req_wdata; m[14] = m[14] & ~req_wdata;
                    end else begin
                        if (idx == 1 && m[1][2] == 1'b0 && req_wdata[2] == 1'b1) exp_rr = 1'b1;
                        m[idx] = req_wdata;
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 rd_valid vs model", {31'b0, rd_valid}, {31'b0, exp_rv});
            if (exp_rv) check("R9 rd_data vs model", rd_data, exp_rd);
            check("R7 reset_req vs model", {31'b0, reset_req}, {31'b0, exp_rr});
            check("R11 int_enable vs model", int_enable, m[14]);
        end
    end

    task automatic access(input bit wr, input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        access(1'b1, 2'b10, a, d);
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sz, input logic [7:0] a, input logic [31:0] exp);
        access(1'b0, sz, a, 32'h0);
        check({tag, " rd_valid"}, {31'b0, rd_valid}, 32'h1);
        check(tag, rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        check("R9 rd_valid in reset", {31'b0, rd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset_req after reset", {31'b0, reset_req}, 32'h0);
        check("R11 int_enable after reset", int_enable, 32'h0);

        // R1 power-on values
        for (int i = 0; i < NREG; i++) rd_chk("R1 reset value", 2'b10, 8'(i*4), por(i));

        // R10 plain storage
        wr(8'h40, 32'hDEAD_BEEF);
        rd_chk("R10 mailbox store", 2'b10, 8'h40, 32'hDEAD_BEEF);
        wr(8'h6C, 32'hA5A5_5A5A);
        rd_chk("R10 last word store", 2'b10, 8'h6C, 32'hA5A5_5A5A);

        // R2 sub-word accesses
        access(1'b1, 2'b00, 8'h44, 32'h1111_1111);
        access(1'b1, 2'b01, 8'h44, 32'h2222_2222);
        rd_chk("R2 sub-word write ignored", 2'b10, 8'h44, 32'h0);
        rd_chk("R2 byte read zero", 2'b00, 8'h08, 32'h0);
        rd_chk("R2 half read zero", 2'b01, 8'h08, 32'h0);

        // R3 misaligned word access
        wr(8'h49, 32'h3333_3333);
        rd_chk("R3 misaligned write ignored", 2'b10, 8'h48, 32'h0);
        rd_chk("R3 misaligned read zero", 2'b10, 8'h0A, 32'h0);

        // R4 / R5 enable aliases
        wr(8'h30, 32'h0000_00F0);
        check("R4 set ORs mask", int_enable, 32'h0000_00F0);
        wr(8'h30, 32'h0000_0F30);
        check("R4 set keeps old bits", int_enable, 32'h0000_0FF0);
        rd_chk("R4 set word stored", 2'b10, 8'h30, 32'h0000_0F30);
        wr(8'h34, 32'h0000_0330);
        check("R5 clear drops bits", int_enable, 32'h0000_0CC0);
        rd_chk("R5 clear word stored", 2'b10, 8'h34, 32'h0000_0330);
        rd_chk("R11 mask readable", 2'b10, 8'h38, 32'h0000_0CC0);

        // R6 read-only words
        wr(8'h38, 32'hFFFF_FFFF);
        check("R6 mask write ignored", int_enable, 32'h0000_0CC0);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd_chk("R6 status write ignored", 2'b10, 8'h3C, 32'h0);

        // R7 reset request edge
        wr(8'h04, 32'h0000_1384);
        check("R7 no pulse when bit stays 1", {31'b0, reset_req}, 32'h0);
        wr(8'h04, 32'h0000_0000);
        check("R7 no pulse when bit clears", {31'b0, reset_req}, 32'h0);
        wr(8'h04, 32'h0000_0004);
        check("R7 pulse on rising bit", {31'b0, reset_req}, 32'h1);
        @(negedge clk);
        check("R7 pulse lasts one cycle", {31'b0, reset_req}, 32'h0);
        rd_chk("R7 new value stored", 2'b10, 8'h04, 32'h0000_0004);

        // R8 undefined offsets
        wr(8'h70, 32'h1234_5678);
        wr(8'hFC, 32'h1234_5678);
        rd_chk("R8 undefined read zero", 2'b10, 8'h70, 32'h0);
        rd_chk("R8 undefined top read zero", 2'b10, 8'hFC, 32'h0);
        rd_chk("R8 no alias into word 0", 2'b10, 8'h00, 32'h0000_0C40);

        // Mixed pseudo-random traffic against the model
        r = 32'h1ACE_B00C;
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            a = r[10] ? {r[7:2], 2'b00} : r[7:0];
            access(r[11], r[12] ? 2'b10 : r[9:8], a, {r[15:0], r[31:16]});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule